// File: doc/BRIEF.md
# Multi-Mode Reconfigurable Memory Controller

This block is a memory module controller that owns a word-addressed storage array. At run time it is set up as one of four access disciplines: a first-in first-out queue, a last-in first-out stack, a linear sequential buffer, or a randomly addressed memory. Apart from a region offset in the random-access mode, the block generates every storage address itself. Processing elements exchange 16-bit words with it through a data-only port and trigger accesses with a strobe. A control unit uses a separate set of lines to select the mode, the direction and the region. It can also push initial load data straight into the array.

The accessible region starts on a boundary of one small region or of two. The small region size is `2**RGN_AW` words: 16K words in a full-size build, a few words in the default build. Full and empty flags tell the processing elements when to stall. Any change of mode or region restarts all pointers at the region base, so a new phase always begins empty.

Top module: `mmc_top`

## Requirements
- R1: After the active-low reset the block is in queue mode on small region 0. `empty_o` is 1, `full_o` is 0 and `rd_data_o` is 0.
- R2: The mode encodings on `cfg_mode_i` are 2'b00 queue, 2'b01 stack, 2'b10 linear and 2'b11 random access. `cfg_wr_i`=1 makes a trigger a write and 0 makes it a read. `cu_load_i` is always a write and needs no trigger. When a load and a processing-element write meet in one cycle, they form a single write that carries `cu_load_data_i`.
- R3: In queue mode, words are read in the order they were written. The occupancy count raises `full_o` when it equals the region size and `empty_o` when it is zero. A write while full and a read while empty are ignored, and an ignored read leaves `rd_data_o` unchanged.
- R4: In queue mode, a read and a write in the same cycle that neither flag blocks both complete and leave the occupancy unchanged.
- R5: In stack mode, pops return the most recent unpopped push, and push and pop counts need not match. A push while full is ignored and `full_o` stays 1. A pop while empty is ignored and `rd_data_o` keeps its last value. A push and a pop in the same cycle on a non-empty stack return the top word and replace it with the new word.
- R6: In linear mode, independent read and write pointers step by one and wrap within the region. Writes always complete and overwrite old words, and reads are never blocked. `full_o` rises once a region's worth of words has been written, and `empty_o` is 1 until the first write.
- R7: In random-access mode, both reads and writes use the word at region base plus `ram_off_i` masked to the region size. Both flags are 0. A read and a write to the same word in one cycle return the old word.
- R8: With `cfg_wide_i`=0 the region base is `cfg_region_i * 2**RGN_AW` and the size is `2**RGN_AW`. With `cfg_wide_i`=1 the base uses `cfg_region_i` with bit 0 cleared and the size doubles. No access leaves its region.
- R9: A change of mode, width or region ignores all accesses in that cycle. In the next cycle the pointers sit at the region base and `empty_o` is 1, except in random-access mode. A change of direction alone resets nothing.
- R10: The block takes one access per trigger in every cycle. Read data appears on `rd_data_o` one clock after the read is accepted and holds until the next accepted read.
- R11: `cu_go_i` and `pe_go_i` each trigger an access in the configured direction, and both together trigger one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 2 | Access mode select |
| cfg_wr_i | input | 1 | Trigger direction, 1 means write |
| cfg_wide_i | input | 1 | Selects the double-size region |
| cfg_region_i | input | MEM_AW-RGN_AW | Region index in small-region units |
| cu_load_i | input | 1 | Control-unit load write strobe |
| cu_load_data_i | input | DATA_W | Load write data |
| cu_go_i | input | 1 | Control-unit access trigger |
| pe_go_i | input | 1 | Processing-element access trigger |
| pe_data_i | input | DATA_W | Processing-element write data |
| ram_off_i | input | RGN_AW+1 | Word offset within the region, used in random-access mode only |
| rd_data_o | output | DATA_W | Registered read data |
| full_o | output | 1 | Region full flag |
| empty_o | output | 1 | Region empty flag |

## Verification
An access or configuration change applied before a rising edge moves the flags by that edge, so they are due one clock later. Read data is registered behind the same edge and is due in that same clock. The bench drives each input set just after a falling edge and updates its own model of the pointers, occupancy and array for the coming rising edge. At the next falling edge it compares `full_o`, `empty_o` and `rd_data_o` against that model. Read data is compared only when the model knows the word that was read, so never-written words are never judged.

// File: rtl/mmc_pkg.sv
package mmc_pkg;
  typedef enum logic [1:0] {
    MODE_FIFO   = 2'b00,
    MODE_STACK  = 2'b01,
    MODE_LINEAR = 2'b10,
    MODE_RAM    = 2'b11
  } mem_mode_e;
endpackage

// File: rtl/mmc_cfg.sv
module mmc_cfg
  import mmc_pkg::*;
#(
  parameter int MEM_AW = 5,
  parameter int RGN_AW = 3,
  localparam int RIDX_W = MEM_AW - RGN_AW,
  localparam int CNT_W  = RGN_AW + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              wide_i,
  input  logic [RIDX_W-1:0] region_i,
  output mem_mode_e         mode_o,
  output logic [MEM_AW-1:0] base_o,
  output logic [CNT_W-1:0]  size_o,
  output logic              reconf_o
);
  mem_mode_e         mode_q;
  logic              wide_q;
  logic [RIDX_W-1:0] region_q;
  logic [RIDX_W-1:0] ridx;

  assign reconf_o = (mode_i != mode_q) || (wide_i != wide_q) || (region_i != region_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_FIFO;
      wide_q   <= 1'b0;
      region_q <= '0;
    end else if (reconf_o) begin
      mode_q   <= mem_mode_e'(mode_i);
      wide_q   <= wide_i;
      region_q <= region_i;
    end
  end

  assign ridx   = wide_q ? (region_q & ~RIDX_W'(1)) : region_q;
  assign base_o = {ridx, {RGN_AW{1'b0}}};
  assign size_o = wide_q ? (CNT_W'(1) << (RGN_AW + 1)) : (CNT_W'(1) << RGN_AW);
  assign mode_o = mode_q;

  p_base_aligned_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide_q |-> (base_o[RGN_AW] == 1'b0));
  p_cfg_taken_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reconf_o |=> (mode_q == $past(mode_i)) && (region_q == $past(region_i)));
endmodule

// File: rtl/mmc_addr_gen.sv
module mmc_addr_gen
  import mmc_pkg::*;
#(
  parameter int MEM_AW = 5,
  parameter int RGN_AW = 3,
  localparam int OFF_W = RGN_AW + 1,
  localparam int CNT_W = RGN_AW + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mem_mode_e         mode_i,
  input  logic [MEM_AW-1:0] base_i,
  input  logic [CNT_W-1:0]  size_i,
  input  logic              reconf_i,
  input  logic              wr_req_i,
  input  logic              rd_req_i,
  input  logic [OFF_W-1:0]  ram_off_i,
  output logic              wr_ok_o,
  output logic              rd_ok_o,
  output logic [MEM_AW-1:0] wr_addr_o,
  output logic [MEM_AW-1:0] rd_addr_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [OFF_W-1:0] wr_off_q, wr_off_d, rd_off_q, rd_off_d;
  logic [OFF_W-1:0] wa, ra, mask, top_m1;

  assign mask    = OFF_W'(size_i - CNT_W'(1));
  assign top_m1  = OFF_W'(cnt_q - CNT_W'(1));
  assign full_o  = (mode_i != MODE_RAM) && (cnt_q == size_i);
  assign empty_o = (mode_i != MODE_RAM) && (cnt_q == '0);

  always_comb begin
    wr_ok_o  = 1'b0;
    rd_ok_o  = 1'b0;
    wa       = wr_off_q;
    ra       = rd_off_q;
    cnt_d    = cnt_q;
    wr_off_d = wr_off_q;
    rd_off_d = rd_off_q;
    if (reconf_i) begin
      cnt_d    = '0;
      wr_off_d = '0;
      rd_off_d = '0;
    end else begin
      unique case (mode_i)
        MODE_FIFO: begin
          wr_ok_o = wr_req_i && !full_o;
          rd_ok_o = rd_req_i && !empty_o;
          if (wr_ok_o) wr_off_d = (wr_off_q + OFF_W'(1)) & mask;
          if (rd_ok_o) rd_off_d = (rd_off_q + OFF_W'(1)) & mask;
          cnt_d = cnt_q + CNT_W'(wr_ok_o) - CNT_W'(rd_ok_o);
        end
        MODE_STACK: begin
          if (rd_req_i && !empty_o) begin
            rd_ok_o = 1'b1;
            ra      = top_m1;
            if (wr_req_i) begin
              wr_ok_o = 1'b1;       // replace top in place
              wa      = top_m1;
            end else begin
              cnt_d = cnt_q - CNT_W'(1);
            end
          end else if (wr_req_i && !full_o) begin
            wr_ok_o = 1'b1;
            wa      = OFF_W'(cnt_q);
            cnt_d   = cnt_q + CNT_W'(1);
          end
        end
        MODE_LINEAR: begin
          wr_ok_o = wr_req_i;
          rd_ok_o = rd_req_i;
          if (wr_ok_o) wr_off_d = (wr_off_q + OFF_W'(1)) & mask;
          if (rd_ok_o) rd_off_d = (rd_off_q + OFF_W'(1)) & mask;
          if (wr_ok_o && cnt_q != size_i) cnt_d = cnt_q + CNT_W'(1);
        end
        default: begin
          wr_ok_o = wr_req_i;
          rd_ok_o = rd_req_i;
          wa      = ram_off_i;
          ra      = ram_off_i;
        end
      endcase
    end
  end

  assign wr_addr_o = base_i | MEM_AW'(wa & mask);
  assign rd_addr_o = base_i | MEM_AW'(ra & mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      wr_off_q <= '0;
      rd_off_q <= '0;
    end else begin
      cnt_q    <= cnt_d;
      wr_off_q <= wr_off_d;
      rd_off_q <= rd_off_d;
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= size_i);
  p_flags_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
  p_reconf_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reconf_i |=> (empty_o || mode_i == MODE_RAM));
  p_ram_noflag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RAM) |-> (!full_o && !empty_o));
  p_fifo_simul_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FIFO && !reconf_i && wr_req_i && rd_req_i && !full_o && !empty_o)
      |=> $stable(cnt_q));
  p_push_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STACK && !reconf_i && full_o && wr_req_i && !rd_req_i) |=> full_o);
endmodule

// File: rtl/mmc_store.sv
module mmc_store #(
  parameter int DATA_W = 16,
  parameter int MEM_AW = 5,
  localparam int DEPTH = 1 << MEM_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [MEM_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [MEM_AW-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  // read sees the word before a same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= mem_q[rd_addr_i];
  end

  p_rd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/mmc_top.sv
module mmc_top
  import mmc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MEM_AW = 5,
  parameter int RGN_AW = 3,
  localparam int RIDX_W = MEM_AW - RGN_AW,
  localparam int OFF_W  = RGN_AW + 1,
  localparam int CNT_W  = RGN_AW + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cfg_mode_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_wide_i,
  input  logic [RIDX_W-1:0] cfg_region_i,
  input  logic              cu_load_i,
  input  logic [DATA_W-1:0] cu_load_data_i,
  input  logic              cu_go_i,
  input  logic              pe_go_i,
  input  logic [DATA_W-1:0] pe_data_i,
  input  logic [OFF_W-1:0]  ram_off_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              full_o,
  output logic              empty_o
);
  mem_mode_e         mode;
  logic [MEM_AW-1:0] base, wr_addr, rd_addr;
  logic [CNT_W-1:0]  size;
  logic              reconf, go, wr_req, rd_req, wr_ok, rd_ok;
  logic [DATA_W-1:0] wr_data;

  assign go      = cu_go_i | pe_go_i;
  assign wr_req  = cu_load_i | (go & cfg_wr_i);
  assign rd_req  = go & ~cfg_wr_i;
  assign wr_data = cu_load_i ? cu_load_data_i : pe_data_i;

  mmc_cfg #(.MEM_AW(MEM_AW), .RGN_AW(RGN_AW)) cfg_i (
    .clk_i, .rst_ni,
    .mode_i(cfg_mode_i), .wide_i(cfg_wide_i), .region_i(cfg_region_i),
    .mode_o(mode), .base_o(base), .size_o(size), .reconf_o(reconf)
  );

  mmc_addr_gen #(.MEM_AW(MEM_AW), .RGN_AW(RGN_AW)) agen_i (
    .clk_i, .rst_ni,
    .mode_i(mode), .base_i(base), .size_i(size), .reconf_i(reconf),
    .wr_req_i(wr_req), .rd_req_i(rd_req), .ram_off_i(ram_off_i),
    .wr_ok_o(wr_ok), .rd_ok_o(rd_ok), .wr_addr_o(wr_addr), .rd_addr_o(rd_addr),
    .full_o(full_o), .empty_o(empty_o)
  );

  mmc_store #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) store_i (
    .clk_i, .rst_ni,
    .wr_en_i(wr_ok), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_ok), .rd_addr_i(rd_addr), .rd_data_o(rd_data_o)
  );

  p_one_trigger_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && !cfg_wr_i && mode == MODE_RAM && !reconf) |-> rd_ok);
  p_load_writes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cu_load_i && mode == MODE_LINEAR && !reconf) |-> wr_ok);
endmodule

// File: tb/mmc_top_tb_top.sv
module mmc_top_tb_top;
  localparam int MEM_AW = 5;
  localparam int RGN_AW = 3;
  localparam int DEPTH  = 1 << MEM_AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic        cfg_wr = 1'b0, cfg_wide = 1'b0;
  logic [1:0]  cfg_region = 2'd0;
  logic        cu_load = 1'b0, cu_go = 1'b0, pe_go = 1'b0;
  logic [15:0] cu_data = '0, pe_data = '0;
  logic [3:0]  ram_off = '0;
  logic [15:0] rd_data;
  logic        full, empty;

  always #4 clk = ~clk;

  mmc_top #(.DATA_W(16), .MEM_AW(MEM_AW), .RGN_AW(RGN_AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_mode_i(cfg_mode), .cfg_wr_i(cfg_wr), .cfg_wide_i(cfg_wide), .cfg_region_i(cfg_region),
    .cu_load_i(cu_load), .cu_load_data_i(cu_data), .cu_go_i(cu_go), .pe_go_i(pe_go),
    .pe_data_i(pe_data), .ram_off_i(ram_off),
    .rd_data_o(rd_data), .full_o(full), .empty_o(empty)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string ph = "R1";

  // model state
  int m_mode = 0, m_reg = 0, m_cnt = 0, m_wo = 0, m_ro = 0;
  bit m_wide = 0;
  logic [15:0] m_rd = '0;
  bit m_rd_known = 1'b1;
  logic [15:0] m_mem [DEPTH];
  bit m_val [DEPTH];

  function automatic int m_size();
    return m_wide ? 16 : 8;
  endfunction
  function automatic int m_base();
    return (m_wide ? (m_reg & ~1) : m_reg) * 8;
  endfunction
  function automatic string mtag();
    case (m_mode)
      0: return "R3";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s/%s %s: actual %h expected %h", ph, mtag(), what, act, exp);
    end
  endtask

  task automatic check_all();
    bit ef, ee;
    ef = (m_mode != 3) && (m_cnt == m_size());
    ee = (m_mode != 3) && (m_cnt == 0);
    chk("full", 16'(full), 16'(ef));
    chk("empty", 16'(empty), 16'(ee));
    if (m_rd_known) chk("R10 rd_data", rd_data, m_rd);
  endtask

  task automatic model_step();
    bit wr, rd, wok, rok;
    int ra, wa, sz, msk;
    logic [15:0] wd;
    wr = cu_load || ((cu_go || pe_go) && cfg_wr);
    rd = (cu_go || pe_go) && !cfg_wr;
    wd = cu_load ? cu_data : pe_data;
    if (int'(cfg_mode) != m_mode || cfg_wide != m_wide || int'(cfg_region) != m_reg) begin
      m_mode = int'(cfg_mode); m_wide = cfg_wide; m_reg = int'(cfg_region);
      m_cnt = 0; m_wo = 0; m_ro = 0;
      return;
    end
    sz = m_size(); msk = sz - 1;
    wok = 0; rok = 0; ra = m_ro; wa = m_wo;
    case (m_mode)
      0: begin
        wok = wr && (m_cnt != sz); rok = rd && (m_cnt != 0);
      end
      1: begin
        if (rd && m_cnt != 0) begin
          rok = 1; ra = m_cnt - 1;
          if (wr) begin wok = 1; wa = m_cnt - 1; end
        end else if (wr && m_cnt != sz) begin
          wok = 1; wa = m_cnt;
        end
      end
      2: begin wok = wr; rok = rd; end
      default: begin wok = wr; rok = rd; ra = int'(ram_off) & msk; wa = ra; end
    endcase
    if (rok) begin
      m_rd = m_mem[m_base() + ra];
      m_rd_known = m_val[m_base() + ra];
    end
    if (wok) begin
      m_mem[m_base() + wa] = wd;
      m_val[m_base() + wa] = 1'b1;
    end
    case (m_mode)
      0: begin
        if (wok) m_wo = (m_wo + 1) & msk;
        if (rok) m_ro = (m_ro + 1) & msk;
        m_cnt = m_cnt + int'(wok) - int'(rok);
      end
      1: begin
        if (rok && !wok) m_cnt--;
        else if (wok && !rok) m_cnt++;
      end
      2: begin
        if (wok) m_wo = (m_wo + 1) & msk;
        if (rok) m_ro = (m_ro + 1) & msk;
        if (wok && m_cnt != sz) m_cnt++;
      end
      default: ;
    endcase
  endtask

  task automatic cyc(input bit ld, input bit cg, input bit pg, input bit dir,
                     input logic [15:0] cd, input logic [15:0] pd, input logic [3:0] off);
    cu_load = ld; cu_go = cg; pe_go = pg; cfg_wr = dir;
    cu_data = cd; pe_data = pd; ram_off = off;
    model_step();
    @(negedge clk);
    check_all();
  endtask

  task automatic set_cfg(input int mode, input bit wide, input int rg);
    cfg_mode = 2'(mode); cfg_wide = wide; cfg_region = 2'(rg);
    cyc(0, 0, 0, 0, 16'h0, 16'h0, 4'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL R10 watchdog: actual hung expected finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) begin m_mem[i] = '0; m_val[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ph = "R1"; check_all();

    // queue fill past full via loads, drain past empty
    ph = "R2";
    for (int i = 0; i < 9; i++) cyc(1, 0, 0, 0, 16'h1000 + 16'(i), 16'h0, 0);
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 0, 16'h0, 16'h0, 0);
    cyc(1, 0, 1, 1, 16'hC0DE, 16'hBAD0, 0);       // load wins over pe write
    cyc(0, 0, 1, 0, 16'h0, 16'h0, 0);
    ph = "R4";
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 16'h2000 + 16'(i), 16'h0, 0);
    for (int i = 0; i < 6; i++) cyc(1, 0, 1, 0, 16'h2100 + 16'(i), 16'h0, 0);

    // stack, asymmetric
    ph = "R9"; set_cfg(1, 0, 1);
    ph = "R5";
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1, 16'h0, 16'h3000 + 16'(i), 0);
    for (int i = 0; i < 2; i++) cyc(0, 0, 1, 0, 16'h0, 16'h0, 0);
    cyc(1, 0, 1, 0, 16'h3AAA, 16'h0, 0);           // push+pop replace
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0, 16'h0, 16'h0, 0);
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 1, 16'h0, 16'h3100 + 16'(i), 0);

    // linear wrap
    ph = "R9"; set_cfg(2, 0, 2);
    ph = "R6";
    for (int i = 0; i < 12; i++) cyc(0, 0, 1, 1, 16'h0, 16'h4000 + 16'(i), 0);
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 0, 16'h0, 16'h0, 0);

    // random access
    ph = "R9"; set_cfg(3, 0, 3);
    ph = "R7";
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, 1, 16'h0, 16'h5000 + 16'(i), 4'(i));
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, 0, 16'h0, 16'h0, 4'(15 - i));
    cyc(1, 0, 1, 0, 16'h5ABC, 16'h0, 4'd2);
    cyc(0, 0, 1, 0, 16'h0, 16'h0, 4'd2);

    // wide region: base 16, size 16
    ph = "R8"; set_cfg(0, 1, 3);
    for (int i = 0; i < 17; i++) cyc(0, 1, 0, 1, 16'h0, 16'h6000 + 16'(i), 0);
    for (int i = 0; i < 17; i++) cyc(0, 0, 1, 0, 16'h0, 16'h0, 0);

    // both triggers together are one access
    ph = "R11";
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 1, 16'h0, 16'h7000 + 16'(i), 0);
    for (int i = 0; i < 4; i++) cyc(0, 1, (i % 2) == 0, 0, 16'h0, 16'h0, 0);

    // direction change alone keeps state; mode change clears it
    ph = "R9";
    cyc(0, 0, 1, 1, 16'h0, 16'h7777, 0);
    cyc(0, 0, 0, 0, 16'h0, 16'h0, 0);
    cyc(0, 0, 1, 0, 16'h0, 16'h0, 0);
    cyc(0, 0, 1, 1, 16'h0, 16'h7778, 0);
    cfg_mode = 2'd1;
    cyc(0, 0, 1, 1, 16'h0, 16'h7779, 0);           // ignored: reconf cycle

    ph = "RND";
    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 64) == 0) begin
        cfg_mode = 2'($urandom); cfg_wide = 1'($urandom); cfg_region = 2'($urandom);
      end
      cyc(($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 2) == 0,
          1'($urandom), 16'($urandom), 16'($urandom), 4'($urandom));
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule